// File: doc/BRIEF.md
# Capture DMA Program Sequencer

This block runs a small program that tells a video capture engine where each scan line goes in memory. It reads pairs of 32-bit words from an instruction memory. The first word of each pair is a command and the second is an argument. It decodes the command and then takes one of these actions:

- It waits for the start of an odd or even field.
- It redirects the fetch pointer to a new address.
- It issues a write request with an address and a byte count to the memory-write logic.

A request can begin a fresh line or continue a line that has been split across memory fragments.

Software loads the program and pulses `start` with the program's byte address. The sequencer then runs by itself. It stops only when it meets an invalid command. At that point it parks, raises `err` and releases `busy`. A new `start` clears `err` and runs again. A command can ask for an interrupt: `irq` then pulses once when that command completes.

The instruction memory answers one cycle after the address is presented. The write port is a level request that is held until it is acknowledged.

Top module: `vdma_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_req`, `irq` and `err` are all low.
- R2: A `start` pulse while not busy loads `base_addr` into the fetch pointer, shown on `imem_addr` one cycle later, and raises `busy`.
- R3: A command is invalid if bit 31 is clear, or if bits 30:28 hold 0, 6 or 7. On an invalid command the block halts with no write, drops `busy` and sets `err`. `err` stays set until the next accepted `start`, which clears it.
- R4: Opcode 1 (line start) raises `wr_req`, with `wr_inline` low and the following fields:
  - `wr_addr` is the argument word.
  - `wr_count` is bits 11:0 of the command.
  - `wr_pos` is bits 23:12.
  - `wr_dtype` is bits 26:24.
- R5: Opcode 2 (inline continuation) issues the same request as R4, with `wr_inline` high.
- R6: A raised `wr_req` and all its fields stay unchanged until `wr_ack` is seen. The fetch pointer does not move before then.
- R7: Opcode 3 (jump) loads the argument word into the fetch pointer and issues no write. The instruction that follows the jump in memory is never executed.
- R8: Opcode 4 waits for an `odd_start` pulse and opcode 5 waits for an `even_start` pulse. While waiting, the fetch pointer holds, and a pulse for the other field has no effect. The argument word of a sync command is ignored.
- R9: Each completed non-jump command advances the fetch pointer by 8.
- R10: A valid command with bit 27 set produces exactly one single-cycle `irq` pulse when it completes. With bit 27 clear there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at `base_addr` (accepted when not busy) |
| base_addr | input | ADDR_W | Byte address of the first command pair |
| imem_addr | output | ADDR_W | Fetch pointer (byte address) to the instruction memory |
| imem_cmd | input | 32 | Command word, valid one cycle after the address |
| imem_arg | input | ADDR_W | Argument word, valid one cycle after the address |
| odd_start | input | 1 | Odd-field start pulse |
| even_start | input | 1 | Even-field start pulse |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | ADDR_W | Destination address of the write |
| wr_pos | output | 12 | Start byte position within the line |
| wr_count | output | 12 | Byte count of the write |
| wr_dtype | output | 3 | Data type code |
| wr_inline | output | 1 | High for a continuation fragment, low for a line start |
| wr_ack | input | 1 | Write acknowledge |
| irq | output | 1 | Single-cycle completion interrupt |
| err | output | 1 | Sticky invalid-command flag |
| busy | output | 1 | Program is executing |

## Verification
The bench builds the block with a 32-bit address and with field starts counted only while a sync command is waiting. This lets a wrong-field pulse be fired into an armed wait and shown to have no effect.

Programs are placed at random base addresses in a 64-pair memory. They mix line starts, inline fragments, both sync kinds and forward jumps over trap commands, and each ends in one of the four invalid encodings. Acknowledge delays of zero to three cycles exercise the holding of the request. Interrupt bits are drawn at random and their pulses are counted over each run.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
   localparam int CMD_W      = 32;
   localparam int CNT_W      = 12;
   localparam int POS_W      = 12;
   localparam int DT_W       = 3;
   localparam int STEP_BYTES = 8;

   typedef enum logic [2:0] {
      K_BAD, K_LINE, K_INL, K_JMP, K_SODD, K_SEVN
   } kind_e;

   typedef struct packed {
      kind_e             kind;
      logic              irq;
      logic [DT_W-1:0]   dtype;
      logic [POS_W-1:0]  pos;
      logic [CNT_W-1:0]  cnt;
   } dec_t;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_DECODE, S_SYNC, S_WRITE, S_HALT
   } state_e;
endpackage

// File: rtl/vdma_decode.sv
module vdma_decode
   import vdma_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   output dec_t             dec
);
   always_comb begin
      dec.irq   = cmd[27];
      dec.dtype = cmd[26:24];
      dec.pos   = cmd[23:12];
      dec.cnt   = cmd[11:0];
      if (!cmd[31]) begin
         dec.kind = K_BAD;
      end else begin
         case (cmd[30:28])
            3'd1:    dec.kind = K_LINE;
            3'd2:    dec.kind = K_INL;
            3'd3:    dec.kind = K_JMP;
            3'd4:    dec.kind = K_SODD;
            3'd5:    dec.kind = K_SEVN;
            default: dec.kind = K_BAD;
         endcase
      end
   end
endmodule

// File: rtl/vdma_field_gate.sv
module vdma_field_gate #(
   parameter bit EARLY_CAPTURE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic odd_in,
   input  logic even_in,
   input  logic arm,
   input  logic consume,
   output logic odd_ok,
   output logic even_ok
);
   logic cap_en;
   logic odd_flag, even_flag;

   generate
      if (EARLY_CAPTURE) begin : g_early
         assign cap_en = 1'b1;
      end else begin : g_armed
         assign cap_en = arm;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || consume) begin
         odd_flag  <= 1'b0;
         even_flag <= 1'b0;
      end else begin
         odd_flag  <= odd_flag  | (odd_in  & cap_en);
         even_flag <= even_flag | (even_in & cap_en);
      end
   end

   assign odd_ok  = odd_flag  | odd_in;
   assign even_ok = even_flag | even_in;
endmodule

// File: rtl/vdma_wr_hold.sv
module vdma_wr_hold
   import vdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [POS_W-1:0]  ld_pos,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic [DT_W-1:0]   ld_dtype,
   input  logic              ld_inline,
   input  logic              ack,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic [POS_W-1:0]  pos,
   output logic [CNT_W-1:0]  cnt,
   output logic [DT_W-1:0]   dtype,
   output logic              inl,
   output logic              done
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req   <= 1'b0;
         addr  <= '0;
         pos   <= '0;
         cnt   <= '0;
         dtype <= '0;
         inl   <= 1'b0;
      end else if (load) begin
         req   <= 1'b1;
         addr  <= ld_addr;
         pos   <= ld_pos;
         cnt   <= ld_cnt;
         dtype <= ld_dtype;
         inl   <= ld_inline;
      end else if (req && ack) begin
         req   <= 1'b0;
      end
   end

   assign done = req & ack;

   // R6: a pending request keeps its level and every field until acknowledged
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(addr) && $stable(pos) && $stable(cnt)
                         && $stable(dtype) && $stable(inl)));
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
   import vdma_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter bit EARLY_CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [CMD_W-1:0]  imem_cmd,
   input  logic [ADDR_W-1:0] imem_arg,
   input  logic              odd_start,
   input  logic              even_start,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [POS_W-1:0]  wr_pos,
   output logic [CNT_W-1:0]  wr_count,
   output logic [DT_W-1:0]   wr_dtype,
   output logic              wr_inline,
   input  logic              wr_ack,
   output logic              irq,
   output logic              err,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

   generate
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
         $error("vdma_seq: ADDR_W must lie in 4..64");
      end
   endgenerate

   state_e            state;
   logic [ADDR_W-1:0] pc;
   dec_t              dec;
   logic              want_odd, irq_pend, irq_q, err_q;
   logic              odd_ok, even_ok, sync_go, ld_wr, wr_done;

   vdma_decode u_dec (.cmd(imem_cmd), .dec(dec));

   vdma_field_gate #(.EARLY_CAPTURE(EARLY_CAPTURE)) u_gate (
      .clk(clk), .rst_n(rst_n), .odd_in(odd_start), .even_in(even_start),
      .arm(state == S_SYNC), .consume(sync_go),
      .odd_ok(odd_ok), .even_ok(even_ok)
   );

   assign ld_wr = (state == S_DECODE) && (dec.kind == K_LINE || dec.kind == K_INL);

   vdma_wr_hold #(.ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .load(ld_wr),
      .ld_addr(imem_arg), .ld_pos(dec.pos), .ld_cnt(dec.cnt),
      .ld_dtype(dec.dtype), .ld_inline(dec.kind == K_INL),
      .ack(wr_ack), .req(wr_req), .addr(wr_addr), .pos(wr_pos),
      .cnt(wr_count), .dtype(wr_dtype), .inl(wr_inline), .done(wr_done)
   );

   assign sync_go = (state == S_SYNC) && (want_odd ? odd_ok : even_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         pc       <= '0;
         want_odd <= 1'b0;
         irq_pend <= 1'b0;
         irq_q    <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (state)
            S_IDLE, S_HALT: begin
               if (start) begin
                  pc    <= base_addr;
                  err_q <= 1'b0;
                  state <= S_FETCH;
               end
            end
            S_FETCH: state <= S_DECODE;
            S_DECODE: begin
               irq_pend <= dec.irq;
               case (dec.kind)
                  K_JMP: begin
                     pc    <= imem_arg;
                     irq_q <= dec.irq;
                     state <= S_FETCH;
                  end
                  K_SODD, K_SEVN: begin
                     want_odd <= (dec.kind == K_SODD);
                     state    <= S_SYNC;
                  end
                  K_LINE, K_INL: state <= S_WRITE;
                  default: begin
                     err_q <= 1'b1;
                     state <= S_HALT;
                  end
               endcase
            end
            S_SYNC: begin
               if (sync_go) begin
                  pc    <= pc + STEP;
                  irq_q <= irq_pend;
                  state <= S_FETCH;
               end
            end
            S_WRITE: begin
               if (wr_done) begin
                  pc    <= pc + STEP;
                  irq_q <= irq_pend;
                  state <= S_FETCH;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign imem_addr = pc;
   assign irq       = irq_q;
   assign err       = err_q;
   assign busy      = (state != S_IDLE) && (state != S_HALT);

   // R2: an accepted start points the fetch at the base and marks the block busy
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && imem_addr == $past(base_addr)));
   // R3: the error flag survives until a start arrives
   p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);
   // R3: with the error flag up nothing is executing or requested
   p_err_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !wr_req));
   // R8: an unsatisfied sync keeps the fetch pointer where it is
   p_sync_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SYNC && !sync_go) |=> (state == S_SYNC && $stable(pc)));
   // R9: an acknowledged write moves the fetch on by one pair
   p_step_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WRITE && wr_done) |=> (imem_addr == $past(imem_addr) + STEP));
   // R10: interrupts are single-cycle pulses
   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: tb/sim_vdma_seq.sv
`timescale 1ns/1ps
module sim_vdma_seq;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n, start, odd_start, even_start, wr_ack;
   logic [AW-1:0] base_addr, imem_addr, imem_arg, wr_addr;
   logic [31:0]   imem_cmd;
   logic          wr_req, wr_inline, irq, err, busy;
   logic [11:0]   wr_pos, wr_count;
   logic [2:0]    wr_dtype;

   logic [31:0]   mem_cmd [0:63];
   logic [31:0]   mem_arg [0:63];
   int            checks = 0;
   int            failures = 0;
   int            irq_seen = 0;
   bit            aborted = 0;

   always #2.5 clk = ~clk;

   vdma_seq #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .imem_addr(imem_addr), .imem_cmd(imem_cmd), .imem_arg(imem_arg),
      .odd_start(odd_start), .even_start(even_start),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_pos(wr_pos), .wr_count(wr_count),
      .wr_dtype(wr_dtype), .wr_inline(wr_inline), .wr_ack(wr_ack),
      .irq(irq), .err(err), .busy(busy)
   );

   always_ff @(posedge clk) begin
      imem_cmd <= mem_cmd[imem_addr[8:3]];
      imem_arg <= mem_arg[imem_addr[8:3]];
   end

   always @(posedge clk) if (rst_n === 1'b1 && irq === 1'b1) irq_seen <= irq_seen + 1;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit is_valid(input logic [31:0] c);
      return c[31] && (c[30:28] >= 3'd1) && (c[30:28] <= 3'd5);
   endfunction

   function automatic logic [31:0] mk_cmd(input logic [2:0] op, input bit irqb);
      logic [31:0] r = $urandom;
      return {1'b1, op, irqb, r[26:0]};
   endfunction

   task automatic build_prog(input int base, input int nitems);
      int idx = base;
      for (int i = 0; i < 64; i++) begin mem_cmd[i] = '0; mem_arg[i] = $urandom; end
      for (int k = 0; k < nitems; k++) begin
         int  r = $urandom % 7;
         bit  ib = 1'($urandom % 2);
         case (r)
            0, 1, 2: begin mem_cmd[idx] = mk_cmd(3'd1, ib); idx++; end
            3:       begin mem_cmd[idx] = mk_cmd(3'd2, ib); idx++; end
            4:       begin mem_cmd[idx] = mk_cmd(3'd4, ib); idx++; end
            5:       begin mem_cmd[idx] = mk_cmd(3'd5, ib); idx++; end
            default: begin
               mem_cmd[idx]     = mk_cmd(3'd3, ib);
               mem_arg[idx]     = 32'((idx + 2) * 8);
               mem_cmd[idx + 1] = mk_cmd(3'd1, 1'b1);   // trap: must be skipped
               idx += 2;
            end
         endcase
      end
      case ($urandom % 4)
         0:       mem_cmd[idx] = {1'b0, 31'($urandom)};
         1:       mem_cmd[idx] = {1'b1, 3'd0, 28'($urandom)};
         2:       mem_cmd[idx] = {1'b1, 3'd6, 28'($urandom)};
         default: mem_cmd[idx] = {1'b1, 3'd7, 28'($urandom)};
      endcase
   endtask

   task automatic wait_cond(input int which, output bit ok);
      ok = 0;
      for (int i = 0; i < 100; i++) begin
         if ((which == 0 && wr_req) || (which == 1 && !busy)) begin ok = 1; return; end
         @(negedge clk);
      end
   endtask

   task automatic pulse_field(input bit odd);
      if (odd) odd_start = 1'b1; else even_start = 1'b1;
      @(negedge clk);
      odd_start = 1'b0; even_start = 1'b0;
   endtask

   task automatic run_prog(input int base);
      int idx = base;
      int exp_irq = 0;
      int irq0 = irq_seen;
      bit after_jump = 0;
      bit ok;
      base_addr = 32'(base * 8);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 fetch address", imem_addr, base * 8);
      chk("R2 busy", busy, 1);
      chk("R3 err cleared by start", err, 0);
      for (int step = 0; step < 64; step++) begin
         logic [31:0] c = mem_cmd[idx];
         if (!is_valid(c)) begin
            wait_cond(1, ok);
            chk("R3 halt drops busy", ok, 1);
            chk("R3 err set", err, 1);
            chk("R3 no write on halt", wr_req, 0);
            chk("R10 irq count", irq_seen - irq0, exp_irq);
            return;
         end
         exp_irq += int'(c[27]);
         case (c[30:28])
            3'd1, 3'd2: begin
               string tag = (c[30:28] == 3'd2) ? "R5" : (after_jump ? "R4 R7" : "R4");
               wait_cond(0, ok);
               chk({tag, " request"}, ok, 1);
               if (!ok) begin aborted = 1; return; end
               chk({tag, " addr"}, wr_addr, mem_arg[idx]);
               chk({tag, " count"}, wr_count, c[11:0]);
               chk({tag, " pos"}, wr_pos, c[23:12]);
               chk({tag, " dtype"}, wr_dtype, c[26:24]);
               chk({tag, " inline"}, wr_inline, (c[30:28] == 3'd2));
               repeat ($urandom % 4) begin
                  @(negedge clk);
                  chk("R6 held req", wr_req, 1);
                  chk("R6 held addr", wr_addr, mem_arg[idx]);
                  chk("R6 held count", wr_count, c[11:0]);
                  chk("R6 fetch holds", imem_addr, idx * 8);
               end
               wr_ack = 1'b1;
               @(negedge clk);
               wr_ack = 1'b0;
               chk("R9 advance by 8", imem_addr, (idx + 1) * 8);
               idx++;
               after_jump = 0;
            end
            3'd3: begin
               idx = int'(mem_arg[idx][8:3]);
               after_jump = 1;
            end
            default: begin
               bit odd = (c[30:28] == 3'd4);
               repeat (6) @(negedge clk);
               chk("R8 waiting at sync", imem_addr, idx * 8);
               pulse_field(!odd);
               repeat (2) @(negedge clk);
               chk("R8 other field ignored", imem_addr, idx * 8);
               chk("R8 no write while waiting", wr_req, 0);
               pulse_field(odd);
               idx++;
               after_jump = 0;
            end
         endcase
      end
      chk("R3 program ended", 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; start = 1'b0; odd_start = 1'b0; even_start = 1'b0;
      wr_ack = 1'b0; base_addr = '0;
      for (int i = 0; i < 64; i++) begin mem_cmd[i] = '0; mem_arg[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 wr_req", wr_req, 0);
      chk("R1 irq", irq, 0);
      chk("R1 err", err, 0);

      // directed: first command invalid (bit 31 clear, IRQ bit set)
      mem_cmd[5] = 32'h7800_0000;
      run_prog(5);

      // directed: jump with interrupt straight to an inline fragment
      build_prog(0, 0);
      mem_cmd[2] = {1'b1, 3'd3, 1'b1, 27'h0};
      mem_arg[2] = 32'd48;
      mem_cmd[3] = mk_cmd(3'd1, 1'b1);
      mem_cmd[6] = {1'b1, 3'd2, 1'b0, 3'd7, 12'hFFF, 12'hFFF};
      mem_cmd[7] = 32'h0;
      run_prog(2);

      for (int t = 0; t < 20 && !aborted; t++) begin
         int base = $urandom % 9;
         build_prog(base, 4 + ($urandom % 7));
         run_prog(base);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule